// File: doc/BRIEF.md
# Fractional-Predivide Clock Divider

This block makes one derived clock, for example a pixel clock or an audio master clock, from one of three source clocks: a crystal reference and two PLL outputs. The block runs on a single system clock. Each source is presented as a one-cycle edge strobe on `src_tick`, one strobe for each rising edge of that source. The selected strobe stream goes through a predivider with a ratio of 2, 2.5 or 3. A second stage then divides by an integer from 2 to 127. The output `clk_out` is a registered level. Its period is the product of the two ratios, counted in source edges. The output can therefore never run faster than a quarter of its source.

Software chooses the source, the predivide ratio, the integer divide value and the enable in one 32-bit control word. The word is write-protected. A write lands only when an unlock strobe has come before it with no other write in between. A write whose settings are illegal is dropped. An accepted word waits as pending state and is applied at the end of the current output period. When it is applied, the output is held low for one clock before the new source and ratios start, so a change never produces a short pulse. There is no data stream here: every pin is a plain control or status level, so no valid/ready back-pressure applies.

Top module: `ckdiv_top`

## Requirements
- R1: Source choice uses control bit 14 and bit 13. With bit 14 clear, `src_tick[0]` drives the divider whatever the value of bit 13. With bit 14 set, bit 13 clear selects `src_tick[1]` and bit 13 set selects `src_tick[2]`.
- R2: Control bits 9:8 hold the predivide code: 1 divides by 2, 2 divides by 2.5 (gaps alternate 2 and 3 source edges), 3 divides by 3. Two consecutive output periods together span (code+3)×N source edges, where N is the divide value.
- R3: Control bits 6:0 hold the integer divide value N, legal from 2 to 127. One output period spans N predivided ticks, and this holds up to N = 127.
- R4: A write with N below 2, or with a predivide code of 0, is discarded even when unlocked. The readback and the output stay unchanged.
- R5: A write is accepted only if an `unlock` pulse came earlier with no write after it. Every write uses up the unlock. A write with no unlock in force is ignored.
- R6: `ctl_rdata` returns the accepted word, with every bit other than 15, 14, 13, 9:8 and 6:0 read as zero.
- R7: While the applied word has bit 15 (enable) clear, `clk_out` stays low.
- R8: A new word takes effect only at the end of the high phase of the current period. The pulse in progress completes at its full old width.
- R9: When a word is applied, `clk_out` is low for at least one clock before the new source is released.
- R10: Within a period, the output is high for ceil(N/2) predivided ticks and low for floor(N/2) ticks.
- R11: After reset, `clk_out` is low and `ctl_rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | Edge strobes of crystal, PLL A, PLL B |
| unlock | input | 1 | One-cycle pulse that arms the next write |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Accepted control word |
| clk_out | output | 1 | Derived clock level |

## Verification
If the predivider phase is wrong, the sum of two consecutive periods is off by at least one source edge. The period measurement that follows shows it. If the lock flag or the legality filter holds a wrong value, `ctl_rdata` shows it on the clock after the write. If the pending or hold logic goes wrong, the high pulse that spans a reconfiguration comes out truncated or too narrow. That shows within one old output period. The bench also measures the first new pulse, so a wrong hold state shows as a first high phase of the wrong width.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int DIV_W    = 7;
  localparam int PD_W     = 2;
  localparam int NUM_SRC  = 3;
  localparam int WORD_W   = 32;
  localparam int PD_LSB   = 8;
  localparam int PSEL_BIT = 13;
  localparam int ESEL_BIT = 14;
  localparam int EN_BIT   = 15;
  localparam int MIN_DIV  = 2;

  typedef struct packed {
    logic            en;
    logic            esel;
    logic            psel;
    logic [PD_W-1:0] pd;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.en   = w[EN_BIT];
    c.esel = w[ESEL_BIT];
    c.psel = w[PSEL_BIT];
    c.pd   = w[PD_LSB +: PD_W];
    c.div  = w[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]            = c.en;
    w[ESEL_BIT]          = c.esel;
    w[PSEL_BIT]          = c.psel;
    w[PD_LSB +: PD_W]    = c.pd;
    w[DIV_W-1:0]         = c.div;
    return w;
  endfunction

  function automatic logic cfg_legal(input cfg_t c);
    return (c.div >= DIV_W'(MIN_DIV)) && (c.pd != '0);
  endfunction
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
  import ckdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rdata,
  output cfg_t              cfg,
  output logic              load,
  output logic              armed
);
  cfg_t ctl_q;
  logic armed_q, load_q;
  cfg_t wr_cfg;

  assign wr_cfg = word_to_cfg(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ctl_q   <= '0;
      load_q  <= 1'b0;
    end else begin
      if (unlock)     armed_q <= 1'b1;
      else if (wr_en) armed_q <= 1'b0;
      if (wr_en && armed_q && cfg_legal(wr_cfg)) begin
        ctl_q  <= wr_cfg;
        load_q <= 1'b1;
      end else begin
        load_q <= 1'b0;
      end
    end
  end

  assign rdata = cfg_to_word(ctl_q);
  assign cfg   = ctl_q;
  assign load  = load_q;
  assign armed = armed_q;
endmodule

// File: rtl/ckdiv_prediv.sv
module ckdiv_prediv
  import ckdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick_in,
  input  logic [PD_W-1:0] code,
  output logic            ptick
);
  logic [1:0] ph_q;
  logic [1:0] last;
  logic       alt_q;

  // last phase index: ratio 2 -> 1, ratio 3 -> 2, ratio 2.5 alternates
  always_comb begin
    case (code)
      2'd1:    last = 2'd1;
      2'd3:    last = 2'd2;
      default: last = alt_q ? 2'd2 : 2'd1;
    endcase
  end

  assign ptick = tick_in && (ph_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ph_q  <= '0;
      alt_q <= 1'b0;
    end else if (tick_in) begin
      if (ph_q == last) begin
        ph_q  <= '0;
        alt_q <= ~alt_q;
      end else begin
        ph_q <= ph_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/ckdiv_intdiv.sv
module ckdiv_intdiv #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ptick,
  input  logic [W-1:0] div,
  output logic         out_q,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_n, lo_len;

  assign lo_len = div >> 1;
  assign wrap   = ptick && (cnt_q == div - W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (ptick) cnt_n = wrap ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      out_q <= (cnt_n >= lo_len);
    end
  end
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
  import ckdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               unlock,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  ctl_rdata,
  output logic               clk_out
);
  cfg_t cfg, act_q;
  logic load, armed, pend_q, hold_q, apply, run, clr;
  logic sel_tick, ptick, wrap, act_en;

  ckdiv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .wr_en(wr_en),
    .wr_data(wr_data), .rdata(ctl_rdata), .cfg(cfg), .load(load),
    .armed(armed)
  );

  always_comb begin
    if (!act_q.esel)     sel_tick = src_tick[0];
    else if (!act_q.psel) sel_tick = src_tick[1];
    else                 sel_tick = src_tick[2];
  end

  assign act_en = act_q.en;
  assign run    = act_q.en && !hold_q;
  assign clr    = !run;
  assign apply  = pend_q && (!act_q.en || wrap);

  ckdiv_prediv u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick_in(sel_tick),
    .code(act_q.pd), .ptick(ptick)
  );

  ckdiv_intdiv #(.W(DIV_W)) u_int (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ptick(ptick),
    .div(act_q.div), .out_q(clk_out), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= apply;
      if (apply)     act_q <= cfg;
      if (apply)     pend_q <= 1'b0;
      else if (load) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] ctl_rdata,
  input logic        clk_out,
  input logic        armed,
  input logic        act_en,
  input logic        apply,
  input logic        hold
);
  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed) |=> $stable(ctl_rdata)); // R5
  AST_ILLEGAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[6:0] < 7'd2 || wr_data[9:8] == 2'd0)) |=> $stable(ctl_rdata)); // R4
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> !clk_out); // R7
  AST_APPLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (!act_en || clk_out)); // R8
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !clk_out); // R9
endmodule

bind ckdiv_top ckdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ctl_rdata(ctl_rdata), .clk_out(clk_out), .armed(armed),
  .act_en(act_en), .apply(apply), .hold(hold_q)
);

// File: tb/sim_ckdiv_top.sv
module sim_ckdiv_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] src_tick = 3'b001;
  logic unlock = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl_rdata;
  logic clk_out;
  int checks = 0, fails = 0;
  bit done = 0;
  int c2 = 0, c3 = 0;

  always #5 clk = ~clk;

  ckdiv_top u0 (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .unlock(unlock),
    .wr_en(wr_en), .wr_data(wr_data), .ctl_rdata(ctl_rdata), .clk_out(clk_out));

  // source strobes: crystal every clock, PLL A every 2nd, PLL B every 3rd
  always @(negedge clk) begin
    c2 <= (c2 == 1) ? 0 : c2 + 1;
    c3 <= (c3 == 2) ? 0 : c3 + 1;
    src_tick <= {c3 == 2, c2 == 1, 1'b1};
  end

  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{16'h8102, 16'h8203, 16'h8305, 16'hC202,
    16'hE104, 16'hE302, 16'h827F, 16'hC207, 16'hA103};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_unlock();
    unlock = 1'b1; cyc(1); unlock = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; cyc(1); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_edge(input bit lvl, output int n);
    n = 0;
    while (clk_out !== lvl && n < 4000) begin cyc(1); n++; end
  endtask

  // clocks spanning two full periods, rise to rise
  task automatic two_periods(output int n);
    int t;
    wait_edge(1'b0, t); wait_edge(1'b1, t);
    n = 0;
    for (int k = 0; k < 2; k++) begin
      wait_edge(1'b0, t); n += t;
      wait_edge(1'b1, t); n += t;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int m, hi, lo;
    cyc(4); rst_n = 1'b1; cyc(2);
    // R11 reset state
    chk(clk_out == 1'b0, "R11 clk_out", clk_out, 0);
    chk(ctl_rdata == 0, "R11 rdata", ctl_rdata, 0);
    // R5 write with no unlock ignored
    do_write(32'h0000_8102); cyc(2);
    chk(ctl_rdata == 0, "R5 locked write", ctl_rdata, 0);
    // R6 readback mask; unlock held across idle cycles
    do_unlock(); cyc(3); do_write(32'hFFFF_FF7F); cyc(1);
    chk(ctl_rdata == 32'h0000_E37F, "R6 readback", ctl_rdata, 32'h0000_E37F);
    // R5 second write without new unlock ignored
    do_write(32'h0000_8102); cyc(1);
    chk(ctl_rdata == 32'h0000_E37F, "R5 unlock consumed", ctl_rdata, 32'h0000_E37F);
    // R4 illegal words dropped even when unlocked
    do_unlock(); do_write(32'h0000_8101); cyc(1);
    chk(ctl_rdata == 32'h0000_E37F, "R4 div1", ctl_rdata, 32'h0000_E37F);
    do_unlock(); do_write(32'h0000_8100); cyc(1);
    chk(ctl_rdata == 32'h0000_E37F, "R4 div0", ctl_rdata, 32'h0000_E37F);
    do_unlock(); do_write(32'h0000_8005); cyc(1);
    chk(ctl_rdata == 32'h0000_E37F, "R4 code0", ctl_rdata, 32'h0000_E37F);

    // R1 R2 R3 table walk
    for (int i = 0; i < NV; i++) begin
      int sp, exp;
      sp  = VEC[i][14] ? (VEC[i][13] ? 3 : 2) : 1;
      exp = (int'(VEC[i][9:8]) + 3) * int'(VEC[i][6:0]) * sp;
      do_unlock(); do_write({16'h0, VEC[i]});
      cyc(2400);
      two_periods(m);
      chk(m == exp, $sformatf("R1 R2 R3 vec%0d", i), m, exp);
    end

    // R10 duty: crystal, ratio 2, N=5 -> high 6, low 4
    do_unlock(); do_write(32'h0000_8105); cyc(2400);
    wait_edge(1'b0, m); wait_edge(1'b1, m);
    wait_edge(1'b0, hi); wait_edge(1'b1, lo);
    chk(hi == 6, "R10 high", hi, 6);
    chk(lo == 4, "R10 low", lo, 4);

    // R8 R9: change mid-pulse from N=10 to N=2
    do_unlock(); do_write(32'h0000_810A); cyc(200);
    wait_edge(1'b0, m); wait_edge(1'b1, m);
    cyc(3); do_unlock(); do_write(32'h0000_8102);
    wait_edge(1'b0, hi);
    chk(hi + 5 == 10, "R8 full old pulse", hi + 5, 10);
    wait_edge(1'b1, lo);
    chk(lo >= 3, "R9 low before new", lo, 3);
    wait_edge(1'b0, hi);
    chk(hi == 2, "R9 first new pulse", hi, 2);

    // R7 disable: output stays low
    do_unlock(); do_write(32'h0000_0102); cyc(50);
    hi = 0;
    for (int k = 0; k < 300; k++) begin cyc(1); if (clk_out) hi++; end
    chk(hi == 0, "R7 disabled low", hi, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule